// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Engine

This block is the device-side control for a small synchronous SRAM that moves data on both halves of its input clock, always in bursts of two words. A command is taken once per input-clock cycle. The command is a load strobe, which is active low, together with a read/write select and an address. A write then takes its two data words during the following cycle. A read presents its two words on the output bus, starting in that same following cycle. When no read is being returned, the bus is released.

Both halves of the input clock are modelled by one clock at twice the rate, `clk2x`, and a phase bit. The block generates the phase bit itself and presents it as `k_phase`. A `clk2x` edge with `k_phase` low stands for the rising edge of the input clock, where commands and the first data word are taken. An edge with `k_phase` high stands for the falling edge, where the second word moves. The second word of a burst always uses the first address with its lowest bit inverted. A release of the bus is shown by `dq_oe` low.

Top module: `ddrb_engine`

## Requirements
- R1: A command slot in which `ld_n` is high is a no-op. For both data slots that would belong to it, `dq_oe` is low.
- R2: A write (`ld_n` low, `rw_n` low) stores `din` into the word at the command address at the next rising slot. It stores `din` into the word at that address with bit 0 inverted at the falling slot after that. `dq_oe` stays low in both slots.
- R3: A read (`ld_n` low, `rw_n` high) drives the word at the command address on `dq_o` with `dq_oe` high. This starts at the rising slot of the following cycle.
- R4: A read drives its second word, taken from the command address with bit 0 inverted, in the falling slot directly after its first word. A start address ending in 0 is followed by 1, and one ending in 1 is followed by 0.
- R5: A new read may be issued in every cycle. Back-to-back reads keep `dq_oe` high with no gap between bursts.
- R6: A read issued in the cycle directly after a write to the same pair returns the newly written words.
- R7: While reset is applied, `dq_oe` is low. The engine leaves reset deselected.
- R8: While `clk2x` is stopped, `dq_o`, `dq_oe` and `k_phase` hold their previous values.
- R9: A command is accepted in every cycle, whatever the previous one was. A write directly after a read to the same pair does not disturb the read's data.
- R10: `k_phase` is low in the first slot after reset is released. It then alternates on every `clk2x` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; each edge is one half of the input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n | input | 1 | Load strobe, active low, sampled when `k_phase` is low |
| rw_n | input | 1 | Direction select: low for write, high for read |
| addr | input | AW | Start address of the burst |
| din | input | DW | Write data, one word per slot |
| dq_o | output | DW | Read data |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |
| k_phase | output | 1 | Slot phase: low for the rising half, high for the falling half |

## Verification
Every address first receives a burst write, once from each start address, so both burst orders of every pair are written. A run of back-to-back reads over all sixteen start addresses then shows the address and order of each word, and shows that the bus is held without a gap. Reads interleaved with no-ops show that the enable falls exactly in the no-op slots. Write-then-read pairs on the same address tell write completion apart from stale array data. Read-then-write pairs, followed by later reads, show that a following write neither corrupts the read nor gets lost. A pause of the clock in the middle of a read burst checks that the outputs hold.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'b00,
    SLOT_WR   = 2'b01,
    SLOT_RD   = 2'b10
  } slot_kind_e;
endpackage

// File: rtl/ddrb_rst_sync.sv
module ddrb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ddrb_phase.sv
module ddrb_phase (
  input  logic clk,
  input  logic srst_n,
  output logic ph
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  assign ph = ph_q;
endmodule

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl
  import ddrb_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          ph,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          out_ld
);
  // first-word stage, loaded in rising slots
  slot_kind_e    p_kind_q, p_kind_d;
  logic [AW-1:0] p_addr_q, p_addr_d;
  // second-word stage, loaded in rising slots, used in falling slots
  slot_kind_e    s_kind_q, s_kind_d;
  logic [AW-1:0] s_addr_q, s_addr_d;
  slot_kind_e    act_kind;

  always_comb begin
    p_kind_d = p_kind_q;
    p_addr_d = p_addr_q;
    s_kind_d = s_kind_q;
    s_addr_d = s_addr_q;
    if (!ph) begin
      if (ld_n)      p_kind_d = SLOT_IDLE;
      else if (rw_n) p_kind_d = SLOT_RD;
      else           p_kind_d = SLOT_WR;
      p_addr_d = addr;
      s_kind_d = p_kind_q;
      s_addr_d = p_addr_q ^ AW'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      p_kind_q <= SLOT_IDLE;
      p_addr_q <= '0;
      s_kind_q <= SLOT_IDLE;
      s_addr_q <= '0;
    end else begin
      p_kind_q <= p_kind_d;
      p_addr_q <= p_addr_d;
      s_kind_q <= s_kind_d;
      s_addr_q <= s_addr_d;
    end
  end

  always_comb begin
    act_kind = ph ? s_kind_q : p_kind_q;
    mem_addr = ph ? s_addr_q : p_addr_q;
    mem_we   = (act_kind == SLOT_WR);
    out_ld   = (act_kind == SLOT_RD);
  end
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/ddrb_engine.sv
module ddrb_engine #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          k_phase
);
  logic          srst_n;
  logic          ph;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic          out_ld;
  logic [DW-1:0] rdata;
  logic [DW-1:0] dq_d;
  logic          oe_d;

  ddrb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk2x), .rst_n(rst_n), .srst_n(srst_n)
  );

  ddrb_phase u_phase (
    .clk(clk2x), .srst_n(srst_n), .ph(ph)
  );

  ddrb_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk2x), .srst_n(srst_n), .ph(ph),
    .ld_n(ld_n), .rw_n(rw_n), .addr(addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .out_ld(out_ld)
  );

  ddrb_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk2x), .we(mem_we), .addr(mem_addr),
    .wdata(din), .rdata(rdata)
  );

  always_comb begin
    oe_d = out_ld;
    dq_d = out_ld ? rdata : dq_o;
  end

  always_ff @(posedge clk2x or negedge srst_n) begin
    if (!srst_n) begin
      dq_oe <= 1'b0;
      dq_o  <= '0;
    end else begin
      dq_oe <= oe_d;
      dq_o  <= dq_d;
    end
  end

  assign k_phase = ph;
endmodule

// File: rtl/ddrb_engine_chk.sv
module ddrb_engine_chk (
  input logic clk2x,
  input logic srst_n,
  input logic k_phase,
  input logic ld_n,
  input logic rw_n,
  input logic dq_oe
);
  // R1: no-op leaves both data slots undriven
  a_r1_nop_no_drive: assert property (@(posedge clk2x) disable iff (!srst_n)
    (!k_phase && ld_n) |-> ##3 !dq_oe ##1 !dq_oe);

  // R2: write never drives the bus
  a_r2_write_no_drive: assert property (@(posedge clk2x) disable iff (!srst_n)
    (!k_phase && !ld_n && !rw_n) |-> ##3 !dq_oe ##1 !dq_oe);

  // R3, R4, R5: read owns the bus for exactly its two slots
  a_r3_read_window: assert property (@(posedge clk2x) disable iff (!srst_n)
    (!k_phase && !ld_n && rw_n) |-> ##3 dq_oe ##1 dq_oe);

  // R10: phase alternates every edge
  a_r10_phase_alternates: assert property (@(posedge clk2x) disable iff (!srst_n)
    1'b1 |=> (k_phase != $past(k_phase)));

  // R7: bus released while in reset
  a_r7_reset_idle: assert property (@(posedge clk2x)
    !srst_n |-> !dq_oe);
endmodule

bind ddrb_engine ddrb_engine_chk u_chk (
  .clk2x(clk2x), .srst_n(srst_n), .k_phase(k_phase),
  .ld_n(ld_n), .rw_n(rw_n), .dq_oe(dq_oe)
);

// File: tb/ddrb_engine_tb.sv
module ddrb_engine_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NCMD = 78;
  localparam int K_NOP = 0, K_WR = 1, K_RD = 2;

  logic          clk2x, rst_n, ld_n, rw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dq_o;
  logic          dq_oe, k_phase;
  logic          clk_run;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] mdl [16];
  logic [DW-1:0] e1 [NCMD];
  logic [DW-1:0] e2 [NCMD];

  ddrb_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk2x(clk2x), .rst_n(rst_n), .ld_n(ld_n), .rw_n(rw_n),
    .addr(addr), .din(din), .dq_o(dq_o), .dq_oe(dq_oe), .k_phase(k_phase)
  );

  initial begin
    clk2x = 1'b0;
    clk_run = 1'b1;
    forever begin
      #2.5;
      if (clk_run) clk2x = ~clk2x;
    end
  end

  function automatic int kind_of(int i);
    if (i < 0 || i >= NCMD) return K_NOP;
    if (i < 16) return K_WR;
    if (i < 32) return K_RD;
    if (i < 48) return (i % 2) ? K_RD : K_NOP;
    if (i < 64) return (i % 2) ? K_RD : K_WR;
    if (i < 72) return (i % 2) ? K_WR : K_RD;
    if (i < 76) return K_RD;
    return K_NOP;
  endfunction

  function automatic int addr_of(int i);
    if (i < 0) return 0;
    if (i < 16) return i;
    if (i < 32) return i - 16;
    if (i < 48) return (i * 3) & 15;
    if (i < 64) return (i % 2) ? (((i - 1) * 5) & 15) : ((i * 5) & 15);
    if (i < 72) return (i % 2) ? (((i - 1) & 15) ^ 1) : (i & 15);
    if (i < 76) return (i - 72) * 2;
    return 0;
  endfunction

  function automatic logic [DW-1:0] w1(int i);
    return DW'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [DW-1:0] w2(int i);
    return DW'((i * 91 + 13) & 255);
  endfunction

  function automatic string seg_tag(int j);
    if (j < 32) return "R5";
    if (j < 48) return "R3";
    if (j < 64) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_slot(int j, int word);
    logic exp_oe;
    exp_oe = (kind_of(j) == K_RD);
    if (!exp_oe) begin
      check((kind_of(j) == K_WR) ? "R2" : "R1", DW'(dq_oe), DW'(0));
    end else begin
      check((word == 1) ? seg_tag(j) : "R4", DW'(dq_oe), DW'(1));
      check((word == 1) ? "R3" : "R4", dq_o, (word == 1) ? e1[j] : e2[j]);
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_d;
    logic          hold_oe, hold_ph;
    rst_n = 1'b0;
    ld_n  = 1'b1;
    rw_n  = 1'b1;
    addr  = '0;
    din   = '0;
    repeat (4) @(negedge clk2x);
    check("R7", DW'(dq_oe), DW'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk2x);
    while (k_phase !== 1'b1) @(negedge clk2x);
    check("R7", DW'(dq_oe), DW'(0));

    for (int i = 0; i < NCMD + 3; i++) begin
      // rising-slot setup: command i, first word of command i-1
      @(negedge clk2x);
      check("R10", DW'(k_phase), DW'(0));
      chk_slot(i - 2, 2);
      ld_n = (kind_of(i) == K_NOP);
      rw_n = (kind_of(i) != K_WR);
      addr = AW'(addr_of(i));
      din  = (kind_of(i - 1) == K_WR) ? w1(i - 1) : '0;
      // falling-slot setup: second word of command i-1
      @(negedge clk2x);
      check("R10", DW'(k_phase), DW'(1));
      if (kind_of(i - 1) == K_RD) begin
        e1[i - 1] = mdl[addr_of(i - 1)];
        e2[i - 1] = mdl[addr_of(i - 1) ^ 1];
      end else if (kind_of(i - 1) == K_WR) begin
        mdl[addr_of(i - 1)]     = w1(i - 1);
        mdl[addr_of(i - 1) ^ 1] = w2(i - 1);
      end
      chk_slot(i - 1, 1);
      din = (kind_of(i - 1) == K_WR) ? w2(i - 1) : '0;
      ld_n = 1'b1;
      if (i == 20) begin
        // R8: pause the clock in the middle of a read burst
        hold_d  = dq_o;
        hold_oe = dq_oe;
        hold_ph = k_phase;
        clk_run = 1'b0;
        #41;
        check("R8", dq_o, hold_d);
        check("R8", DW'(dq_oe), DW'(hold_oe));
        check("R8", DW'(k_phase), DW'(hold_ph));
        clk_run = 1'b1;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule